// File: doc/BRIEF.md
# Interrupt Input to Priority-Level Mapper

This block gathers eight level-sensitive peripheral interrupt lines and presents them to a processor as sixteen priority-level request lines. Every input is routed to one fixed priority level. The routing is sparse: several levels never receive an input, and two inputs route to level 0, which counts as "no level", so those inputs are ignored. Any number of active inputs may drive their levels at the same time. Each level output is the OR of the pending inputs routed to it.

A single byte-wide control register sits on a minimal one-byte bus window and can be read and written at any time. Bit 0 of this register is a global enable. While it is clear, every level output is held low, but the pending mask still follows the inputs. Bit 6 cannot be stored. The pending mask and the level outputs are registered. A change on an input, or a register write, reaches the outputs on the first rising clock edge that samples it.

Top module: `irq_level_map`

## Requirements
- R1: While reset is asserted and after it is released with no write, `bus_rdata` reads 0x01 and every bit of `lvl_out` is 0.
- R2: A write (`bus_sel`=1 and `bus_we`=1 at a rising edge) stores `bus_wdata & 0xBF`, so bit 6 of the register is always 0.
- R3: `bus_rdata` always shows the current register byte, with no read strobe and no extra cycle.
- R4: Inputs 1, 2, 3, 4, 5 and 7 drive the level outputs 1, 4, 6, 8, 10 and 14, in that order.
- R5: Inputs 0 and 6 route to level 0 and are ignored: no value on them changes any level output.
- R6: The pending mask follows the inputs. When an input falls, its level output falls on the next rising edge. Nothing is latched.
- R7: Several inputs that are high together drive all of their levels at the same time.
- R8: `lvl_out` bits 0, 2, 3, 5, 7, 9, 11, 12, 13 and 15 are never 1.
- R9: While register bit 0 is 0, all of `lvl_out` is 0. The pending mask keeps following the inputs while the enable is off, so the write that sets bit 0 again shows the current inputs on the same edge.
- R10: `lvl_out` changes on the first rising edge that samples an input change or a register write, and on no later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock. The interrupt inputs are synchronous to it. |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Selects the one-byte register window |
| bus_we | input | 1 | Write strobe. Valid only together with `bus_sel`. |
| bus_wdata | input | 8 | Byte to write |
| bus_rdata | output | 8 | Current register byte |
| irq_in | input | 8 | Level-sensitive peripheral interrupt inputs 0 to 7 |
| lvl_out | output | 16 | Priority-level request lines 0 to 15 |

## Verification
A register write appears on `bus_rdata` and `lvl_out` after the one rising edge that samples it. An input change appears on `lvl_out` after that same single edge. The bench's driver applies each stimulus on a falling edge and waits for the next rising edge. It then updates its own model and queues the expected output pair. The monitor pops and compares that pair on the following falling edge, which is the first stable point after the result is due and comes before any later stimulus.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
  localparam int unsigned NUM_IN   = 8;
  localparam int unsigned NUM_LVL  = 16;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned LVL_IDXW = $clog2(NUM_LVL);

  // Fixed routing of interrupt input index to priority level (0 = unrouted)
  function automatic logic [LVL_IDXW-1:0] level_of(input int unsigned idx);
    logic [LVL_IDXW-1:0] l;
    case (idx)
      1:       l = LVL_IDXW'(1);
      2:       l = LVL_IDXW'(4);
      3:       l = LVL_IDXW'(6);
      4:       l = LVL_IDXW'(8);
      5:       l = LVL_IDXW'(10);
      7:       l = LVL_IDXW'(14);
      default: l = '0;
    endcase
    return l;
  endfunction

  // Set of levels that at least one input can reach
  function automatic logic [NUM_LVL-1:0] reachable_levels();
    logic [NUM_LVL-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NUM_IN; i++) begin
      if (level_of(i) != '0) m[level_of(i)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irqmap_rst_sync.sv
module irqmap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irqmap_ctl.sv
module irqmap_ctl #(
  parameter int unsigned      DW      = 8,
  parameter logic [DW-1:0]    WMASK   = 8'hBF,
  parameter logic [DW-1:0]    RST_VAL = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] ctl_d,
  output logic [DW-1:0] ctl_q
);
  always_comb begin
    ctl_d = wr_en ? (wr_data & WMASK) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= RST_VAL;
    else if (wr_en) ctl_q <= ctl_d;
  end

  // R2: stored value is the masked write byte
  p_write_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q == ($past(wr_data) & WMASK));

  // R2: bits outside the mask never hold a 1
  p_masked_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q & ~WMASK) == '0);

  // R3: register holds when not written
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
endmodule

// File: rtl/irqmap_pend.sv
module irqmap_pend
  import irqmap_pkg::*;
#(
  parameter int unsigned N = NUM_IN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  output logic [N-1:0] pend_d,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    if (level_of(i) == '0) begin : g_unrouted
      always_comb pend_d[i] = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[i] <= 1'b0;
        else        pend_q[i] <= pend_d[i];
      end
      // R5: unrouted inputs never become pending
      p_unrouted_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[i]);
    end else begin : g_routed
      always_comb pend_d[i] = irq_in[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q[i] <= 1'b0;
        else        pend_q[i] <= pend_d[i];
      end
      // R6: pending bit follows its input one edge later
      p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_q[i] == $past(irq_in[i]));
    end
  end
endmodule

// File: rtl/irqmap_fold.sv
module irqmap_fold
  import irqmap_pkg::*;
#(
  parameter int unsigned N = NUM_IN,
  parameter int unsigned L = NUM_LVL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend_d,
  input  logic         en_d,
  output logic [L-1:0] lvl_q
);
  logic [N-1:0] route [L];
  logic [L-1:0] lvl_d;

  for (genvar lv = 0; lv < L; lv++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_in
      if (lv != 0 && level_of(i) == lv) begin : g_hit
        assign route[lv][i] = pend_d[i];
      end else begin : g_miss
        assign route[lv][i] = 1'b0;
      end
    end
    assign lvl_d[lv] = en_d & (|route[lv]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  // R8: level 0 is never requested
  p_level0_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_q[0]);

  // R8: unreachable levels stay low
  p_unreachable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & ~reachable_levels()) == '0);
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irqmap_pkg::*;
#(
  parameter int unsigned          DW      = REG_W,
  parameter logic [REG_W-1:0]     WMASK   = 8'hBF,
  parameter logic [REG_W-1:0]     RST_VAL = 8'h01,
  parameter int unsigned          EN_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic [NUM_LVL-1:0] lvl_out
);
  logic              rst_n_s;
  logic              wr_en;
  logic [DW-1:0]     ctl_d;
  logic [DW-1:0]     ctl_q;
  logic [NUM_IN-1:0] pend_d;
  logic [NUM_IN-1:0] pend_q;

  assign wr_en = bus_sel & bus_we;

  irqmap_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  irqmap_ctl #(.DW(DW), .WMASK(WMASK), .RST_VAL(RST_VAL)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (wr_en),
    .wr_data (bus_wdata),
    .ctl_d   (ctl_d),
    .ctl_q   (ctl_q)
  );

  irqmap_pend #(.N(NUM_IN)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .irq_in (irq_in),
    .pend_d (pend_d),
    .pend_q (pend_q)
  );

  irqmap_fold #(.N(NUM_IN), .L(NUM_LVL)) u_fold (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .pend_d (pend_d),
    .en_d   (ctl_d[EN_BIT]),
    .lvl_q  (lvl_out)
  );

  assign bus_rdata = ctl_q;

  // R9: disabled register forces every level low
  p_disabled_low_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ctl_q[EN_BIT] |-> lvl_out == '0);

  // R10: with the enable on, a routed pending input shows on its level in the same cycle
  p_pend_to_level_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctl_q[EN_BIT] && pend_q[1]) |-> lvl_out[level_of(1)]);

  // R1: register reads the reset value in the first cycle after reset release
  p_reset_value_r1: assert property (@(posedge clk)
    $rose(rst_n_s) |-> bus_rdata == RST_VAL);
endmodule

// File: tb/sim_irq_level_map.sv
`timescale 1ns/1ps
module sim_irq_level_map;
  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [7:0]  irq_in;
  logic [15:0] lvl_out;

  int checks;
  int failures;
  bit done;

  typedef struct {
    logic [15:0] lvl;
    logic [7:0]  rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] reg_m;

  irq_level_map u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (irq_in),
    .lvl_out   (lvl_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference routing taken from R4/R5
  function automatic logic [15:0] ref_levels(input logic [7:0] irq, input logic en);
    int tbl [8] = '{0, 1, 4, 6, 8, 10, 0, 14};
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (irq[i] && tbl[i] != 0) r[tbl[i]] = 1'b1;
    end
    return en ? r : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] lvl_e, input logic [7:0] rd_e);
    checks++;
    if (lvl_out !== lvl_e || bus_rdata !== rd_e) begin
      failures++;
      $display("FAIL %s: lvl=%h rd=%h expected lvl=%h rd=%h", tag, lvl_out, bus_rdata, lvl_e, rd_e);
    end
  endtask

  // Driver: one stimulus, then queue the expected result due after the sampling edge
  task automatic step(input logic [7:0] irq, input logic we, input logic [7:0] wd, input string tag);
    exp_t e;
    @(negedge clk);
    irq_in    = irq;
    bus_sel   = we;
    bus_we    = we;
    bus_wdata = wd;
    @(posedge clk);
    if (we) reg_m = wd & 8'hBF;
    e.lvl = ref_levels(irq, reg_m[0]);
    e.rd  = reg_m;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    bus_sel = 1'b0;
    bus_we  = 1'b0;
  endtask

  // Monitor: compare on the falling edge after each result is due
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, e.lvl, e.rd);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: lvl=%h rd=%h expected completion", lvl_out, bus_rdata);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0; irq_in = '0;
    reg_m = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 16'h0000, 8'h01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 16'h0000, 8'h01);

    // R4: each routed input alone
    step(8'h02, 0, 8'h00, "R4 in1->L1");
    step(8'h04, 0, 8'h00, "R4 in2->L4");
    step(8'h08, 0, 8'h00, "R4 in3->L6");
    step(8'h10, 0, 8'h00, "R4 in4->L8");
    step(8'h20, 0, 8'h00, "R4 in5->L10");
    step(8'h80, 0, 8'h00, "R4 in7->L14");
    // R5: unrouted inputs ignored
    step(8'h41, 0, 8'h00, "R5 in0+in6 ignored");
    step(8'hC1, 0, 8'h00, "R5 in7 with unrouted");
    // R6: falling input clears its level next edge
    step(8'h00, 0, 8'h00, "R6 release");
    step(8'h00, 0, 8'h00, "R6 stays low");
    // R7: several at once
    step(8'hBE, 0, 8'h00, "R7 all routed");
    step(8'hFF, 0, 8'h00, "R7 R8 all inputs");
    step(8'h14, 0, 8'h00, "R7 in2+in4");
    // R2/R3: masked write, read back
    step(8'h14, 1, 8'hFF, "R2 write FF reads BF");
    step(8'h14, 1, 8'h40, "R2 R9 write 40 disables");
    // R9: pending follows while disabled
    step(8'h28, 0, 8'h00, "R9 disabled input change");
    step(8'h08, 0, 8'h00, "R9 disabled still low");
    step(8'h08, 1, 8'h01, "R9 R10 re-enable shows current");
    step(8'h88, 1, 8'h5B, "R3 R10 write+input same edge");
    step(8'h00, 1, 8'hA5, "R3 readback A5");
    step(8'h02, 0, 8'h00, "R10 single edge");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule